// File: doc/BRIEF.md
# Row-Tag Timing Selector

This block keeps a small direct-mapped store of DRAM row addresses whose contents currently live in a fast, short-bitline region of the memory device. For each activate that the controller issues, the block looks up the row. It then hands the command scheduler the timing constraints, in clock cycles, that apply to that access. A resident row gets a reduced set of constraints. Any other row gets the normal set.

Tags carry only the row address and a valid bit. The fast region is write-through, so there is no dirty state and nothing to write back. The migration logic fills slots through a separate install port, which supplies both the row and the slot to overwrite.

The reduced column-access and write-recovery values are only usable when the fast region sits close to the I/O. A configuration input enables them. When it is low, those two values stay at their normal figures even on a hit.

Top module: `row_tag_timing`

## Requirements
- R1: After reset, `res_valid` and `res_hit` are 0 and every timing output holds its miss value. Every slot is empty, so any lookup misses until an install occurs.
- R2: A lookup strobed on `lk_valid` in cycle N produces its result in cycle N+1, with `res_valid` high for exactly that one cycle.
- R3: A lookup hits when the slot indexed by the low log2(SLOTS) bits of `lk_row` is valid and holds the full `lk_row` value.
- R4: On a miss the outputs are tRCD 11, tRP 11, tRAS 28, tRC 39, tAA 11, tWR 12 cycles (1.25 ns clock).
- R5: On a hit, tRCD, tRP, tRAS and tRC are 7, 7, 12 and 19 cycles.
- R6: On a hit with `col_fast_en` high at the lookup, tAA is 7 and tWR is 8. With it low, they stay 11 and 12.
- R7: An install writes `ins_row` into slot `ins_slot` and marks it valid, replacing any earlier tag there. A row installed in a slot other than its own index never hits.
- R8: A lookup in the same cycle as an install sees the tag store as it was before that install. Later lookups see the new tag.
- R9: In cycles after no lookup, `res_hit` is 0 and the timing outputs keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup strobe, one per activate |
| lk_row | input | ROW_W | Row address to look up |
| ins_valid | input | 1 | Install strobe |
| ins_row | input | ROW_W | Row address to install |
| ins_slot | input | log2(SLOTS) | Slot to overwrite |
| col_fast_en | input | 1 | Enables reduced tAA and tWR on hits |
| res_valid | output | 1 | Result strobe, one cycle after lookup |
| res_hit | output | 1 | Row was resident |
| t_rcd | output | TW | Activate-to-column delay, cycles |
| t_rp | output | TW | Precharge time, cycles |
| t_ras | output | TW | Activate-to-precharge minimum, cycles |
| t_rc | output | TW | Row cycle time, cycles |
| t_aa | output | TW | Column access latency, cycles |
| t_wr | output | TW | Write recovery, cycles |

## Verification
A corrupted tag or valid bit shows up in the result cycle of the first lookup that indexes the slot. It appears as a wrong `res_hit`, together with a whole timing set from the wrong table. The bench therefore looks up each installed row right after its install. It also looks up aliasing rows that share an index, so a comparison over too few address bits appears within one cycle. Ordering faults between an install and a lookup in the same cycle are caught by comparing the lookups in the same cycle and in the next cycle against the state the bench itself tracks.

// File: rtl/row_tag_timing.sv
module row_tag_timing #(
  parameter int ROW_W    = 14,
  parameter int SLOTS    = 16,
  parameter int TW       = 6,
  parameter int MISS_RCD = 11,
  parameter int MISS_RP  = 11,
  parameter int MISS_RAS = 28,
  parameter int MISS_RC  = 39,
  parameter int MISS_AA  = 11,
  parameter int MISS_WR  = 12,
  parameter int HIT_RCD  = 7,
  parameter int HIT_RP   = 7,
  parameter int HIT_RAS  = 12,
  parameter int HIT_RC   = 19,
  parameter int HIT_AA   = 7,
  parameter int HIT_WR   = 8,
  localparam int IDX_W   = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [ROW_W-1:0] lk_row,
  input  logic             ins_valid,
  input  logic [ROW_W-1:0] ins_row,
  input  logic [IDX_W-1:0] ins_slot,
  input  logic             col_fast_en,
  output logic             res_valid,
  output logic             res_hit,
  output logic [TW-1:0]    t_rcd,
  output logic [TW-1:0]    t_rp,
  output logic [TW-1:0]    t_ras,
  output logic [TW-1:0]    t_rc,
  output logic [TW-1:0]    t_aa,
  output logic [TW-1:0]    t_wr
);

  logic [ROW_W-1:0] tag_q [SLOTS];
  logic [SLOTS-1:0] vld_q;

  wire [IDX_W-1:0] lk_idx  = lk_row[IDX_W-1:0];
  wire             hit_now = vld_q[lk_idx] && (tag_q[lk_idx] == lk_row);
  wire             col_hit = hit_now && col_fast_en;

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else if (ins_valid) vld_q[ins_slot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (ins_valid) tag_q[ins_slot] <= ins_row;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      t_rcd     <= TW'(MISS_RCD);
      t_rp      <= TW'(MISS_RP);
      t_ras     <= TW'(MISS_RAS);
      t_rc      <= TW'(MISS_RC);
      t_aa      <= TW'(MISS_AA);
      t_wr      <= TW'(MISS_WR);
    end else begin
      res_valid <= lk_valid;
      res_hit   <= lk_valid && hit_now;
      if (lk_valid) begin
        t_rcd <= hit_now ? TW'(HIT_RCD) : TW'(MISS_RCD);
        t_rp  <= hit_now ? TW'(HIT_RP)  : TW'(MISS_RP);
        t_ras <= hit_now ? TW'(HIT_RAS) : TW'(MISS_RAS);
        t_rc  <= hit_now ? TW'(HIT_RC)  : TW'(MISS_RC);
        t_aa  <= col_hit ? TW'(HIT_AA)  : TW'(MISS_AA);
        t_wr  <= col_hit ? TW'(HIT_WR)  : TW'(MISS_WR);
      end
    end
  end

endmodule

// File: rtl/row_tag_timing_chk.sv
module row_tag_timing_chk #(
  parameter int TW       = 6,
  parameter int MISS_RCD = 11,
  parameter int MISS_RP  = 11,
  parameter int MISS_RAS = 28,
  parameter int MISS_RC  = 39,
  parameter int MISS_AA  = 11,
  parameter int MISS_WR  = 12,
  parameter int HIT_RCD  = 7,
  parameter int HIT_RP   = 7,
  parameter int HIT_RAS  = 12,
  parameter int HIT_RC   = 19,
  parameter int HIT_AA   = 7,
  parameter int HIT_WR   = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lk_valid,
  input logic          col_fast_en,
  input logic          res_valid,
  input logic          res_hit,
  input logic [TW-1:0] t_rcd,
  input logic [TW-1:0] t_rp,
  input logic [TW-1:0] t_ras,
  input logic [TW-1:0] t_rc,
  input logic [TW-1:0] t_aa,
  input logic [TW-1:0] t_wr
);

  assert_result_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);

  assert_no_spurious_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);

  assert_miss_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (t_rcd == TW'(MISS_RCD) && t_rp == TW'(MISS_RP) &&
      t_ras == TW'(MISS_RAS) && t_rc == TW'(MISS_RC) && t_aa == TW'(MISS_AA) && t_wr == TW'(MISS_WR)));

  assert_hit_row_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> (t_rcd == TW'(HIT_RCD) && t_rp == TW'(HIT_RP) &&
      t_ras == TW'(HIT_RAS) && t_rc == TW'(HIT_RC)));

  assert_col_fast_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && col_fast_en) |=> (res_hit ? (t_aa == TW'(HIT_AA) && t_wr == TW'(HIT_WR))
                                          : (t_aa == TW'(MISS_AA) && t_wr == TW'(MISS_WR))));

  assert_col_slow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !col_fast_en) |=> (t_aa == TW'(MISS_AA) && t_wr == TW'(MISS_WR)));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!res_hit && $stable(t_rcd) && $stable(t_rc) && $stable(t_aa) && $stable(t_wr)));

endmodule

bind row_tag_timing row_tag_timing_chk #(
  .TW(TW), .MISS_RCD(MISS_RCD), .MISS_RP(MISS_RP), .MISS_RAS(MISS_RAS), .MISS_RC(MISS_RC),
  .MISS_AA(MISS_AA), .MISS_WR(MISS_WR), .HIT_RCD(HIT_RCD), .HIT_RP(HIT_RP), .HIT_RAS(HIT_RAS),
  .HIT_RC(HIT_RC), .HIT_AA(HIT_AA), .HIT_WR(HIT_WR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .col_fast_en(col_fast_en),
  .res_valid(res_valid), .res_hit(res_hit), .t_rcd(t_rcd), .t_rp(t_rp), .t_ras(t_ras),
  .t_rc(t_rc), .t_aa(t_aa), .t_wr(t_wr)
);

// File: tb/row_tag_timing_tb.sv
module row_tag_timing_tb;
  localparam int ROW_W = 14;
  localparam int SLOTS = 16;
  localparam int IW    = 4;
  localparam int TW    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, ins_valid = 1'b0, col_fast_en = 1'b0;
  logic [ROW_W-1:0] lk_row = '0, ins_row = '0;
  logic [IW-1:0] ins_slot = '0;
  logic res_valid, res_hit;
  logic [TW-1:0] t_rcd, t_rp, t_ras, t_rc, t_aa, t_wr;

  int n_chk = 0, n_bad = 0;
  logic [ROW_W-1:0] m_tag [SLOTS];
  logic [SLOTS-1:0] m_vld = '0;

  always #2 clk = ~clk;

  row_tag_timing u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_row(lk_row),
    .ins_valid(ins_valid), .ins_row(ins_row), .ins_slot(ins_slot),
    .col_fast_en(col_fast_en), .res_valid(res_valid), .res_hit(res_hit),
    .t_rcd(t_rcd), .t_rp(t_rp), .t_ras(t_ras), .t_rc(t_rc), .t_aa(t_aa), .t_wr(t_wr)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_set(string req, bit hit, bit fast);
    chk(req, "res_valid", int'(res_valid), 1);
    chk(req, "res_hit", int'(res_hit), int'(hit));
    chk(req, "t_rcd", int'(t_rcd), hit ? 7 : 11);
    chk(req, "t_rp",  int'(t_rp),  hit ? 7 : 11);
    chk(req, "t_ras", int'(t_ras), hit ? 12 : 28);
    chk(req, "t_rc",  int'(t_rc),  hit ? 19 : 39);
    chk(req, "t_aa",  int'(t_aa),  (hit && fast) ? 7 : 11);
    chk(req, "t_wr",  int'(t_wr),  (hit && fast) ? 8 : 12);
  endtask

  function automatic bit model_hit(logic [ROW_W-1:0] r);
    return m_vld[r[IW-1:0]] && m_tag[r[IW-1:0]] == r;
  endfunction

  task automatic install(logic [ROW_W-1:0] r, logic [IW-1:0] s);
    ins_valid = 1'b1; ins_row = r; ins_slot = s;
    @(negedge clk);
    ins_valid = 1'b0;
    m_tag[s] = r; m_vld[s] = 1'b1;
  endtask

  task automatic lookup(string req, logic [ROW_W-1:0] r, bit fast);
    bit h;
    h = model_hit(r);
    lk_valid = 1'b1; lk_row = r; col_fast_en = fast;
    @(negedge clk);
    lk_valid = 1'b0;
    chk_set(req, h, fast);
  endtask

  task automatic t_reset_state;
    chk("R1", "res_valid", int'(res_valid), 0);
    chk("R1", "res_hit", int'(res_hit), 0);
    chk("R1", "t_rc", int'(t_rc), 39);
    chk("R1", "t_wr", int'(t_wr), 12);
    for (int i = 0; i < 4; i++) lookup("R1", ROW_W'(i * 37), 1'b1);
  endtask

  task automatic t_miss_hit;
    lookup("R4", 14'h0123, 1'b1);
    install(14'h0123, 4'h3);
    lookup("R5", 14'h0123, 1'b0);
    lookup("R3", 14'h1123, 1'b0);
    @(negedge clk);
    chk("R2", "res_valid idle", int'(res_valid), 0);
  endtask

  task automatic t_col_cfg;
    install(14'h2a5c, 4'hc);
    lookup("R6", 14'h2a5c, 1'b1);
    lookup("R6", 14'h2a5c, 1'b0);
    lookup("R6", 14'h0a5c, 1'b1);
  endtask

  task automatic t_alias_slot;
    install(14'h0040, 4'h7);
    lookup("R7", 14'h0040, 1'b1);
    install(14'h3ff7, 4'h7);
    lookup("R7", 14'h3ff7, 1'b1);
    install(14'h1237, 4'h7);
    lookup("R7", 14'h3ff7, 1'b1);
    lookup("R7", 14'h1237, 1'b1);
  endtask

  task automatic t_same_cycle;
    bit h;
    h = model_hit(14'h0555);
    lk_valid = 1'b1; lk_row = 14'h0555; col_fast_en = 1'b1;
    ins_valid = 1'b1; ins_row = 14'h0555; ins_slot = 4'h5;
    @(negedge clk);
    lk_valid = 1'b0; ins_valid = 1'b0;
    m_tag[5] = 14'h0555; m_vld[5] = 1'b1;
    chk_set("R8", h, 1'b1);
    chk("R8", "old-state miss", int'(h), 0);
    lookup("R8", 14'h0555, 1'b1);
  endtask

  task automatic t_hold;
    lookup("R9", 14'h0555, 1'b1);
    @(negedge clk);
    chk("R9", "res_hit idle", int'(res_hit), 0);
    chk("R9", "t_rc hold", int'(t_rc), 19);
    chk("R9", "t_aa hold", int'(t_aa), 7);
    install(14'h0999, 4'h9);
    chk("R9", "t_ras hold", int'(t_ras), 12);
  endtask

  task automatic t_fill_all;
    for (int s = 0; s < SLOTS; s++) install(ROW_W'(s + 16 * (s + 3)), IW'(s));
    for (int s = 0; s < SLOTS; s++) lookup("R3", ROW_W'(s + 16 * (s + 3)), s[0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_miss_hit();
    t_col_cfg();
    t_alias_slot();
    t_same_cycle();
    t_hold();
    t_fill_all();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule